// File: doc/BRIEF.md
# Instruction Prefetch Queue Unit

This unit runs ahead of an execution unit and keeps a small first-in first-out store of instruction bytes topped up. It holds a 16-bit code segment and a 16-bit fetch pointer. It forms a 20-bit physical address from them and issues fetches on a 16-bit memory bus. Each bus fetch occupies a fixed number of clock cycles. The execution unit drains the store one byte at a time through a valid/ready handshake.

New fetches start only when the store has room for a full bus word. No fetch starts while the execution unit holds the bus for a data access. A branch request throws away every queued byte and reloads the segment and pointer. If a fetch is already on the bus when the branch arrives, that fetch runs to its end and its data is discarded. If the pointer is odd, the next fetch reads a single byte, and every fetch after it is word-aligned.

Top module: `ifetch_queue`

## Requirements
- R1: Bytes leave through `q_byte_o` in the order they were fetched, from lower address to higher address. The store holds at most 6 bytes. A byte is consumed on a clock edge where `q_valid_o` and `q_ready_i` are both high and `branch_i` is low.
- R2: A fetch starts only in a cycle where at most 4 bytes are held, so that at least 2 entries are free. At most one fetch is on the bus at any time. Once the store is full, no request is issued until it drains to 4 bytes or fewer.
- R3: The fetch address is the code segment times 16 plus the pointer, reduced to 20 bits. The pointer wraps modulo 2^16 inside its segment.
- R4: When the pointer is even, the fetch is a word fetch with `mem_word_o`=1. Byte `mem_rdata_i[7:0]` (the even address) is queued before `mem_rdata_i[15:8]`, and the pointer advances by 2.
- R5: When the pointer is odd, the fetch is a byte fetch with `mem_word_o`=0. Only `mem_rdata_i[15:8]` is queued, and the pointer advances by 1.
- R6: A fetch holds `mem_req_o` high for exactly 4 consecutive cycles, with the address and size held steady. Read data is taken in the 4th cycle. The request is low for at least one cycle between two fetches, and it rises one cycle after the cycle in which the start conditions held.
- R7: No fetch starts in a cycle where `data_req_i` is high. A fetch already on the bus still completes and delivers its data.
- R8: When `branch_i` is high, the store is emptied and any pop in that cycle is discarded. The segment and pointer load `branch_cs_i` and `branch_ip_i`. No fetch starts in that cycle, and the next fetch goes to the new address.
- R9: If a fetch is on the bus when `branch_i` is high, including in its last cycle, it still occupies the bus for its full length. None of its bytes enters the store.
- R10: `q_valid_o` is low whenever the store is empty. Bytes taken in a bus cycle's last cycle are visible on the next cycle.
- R11: A pop and a bus delivery on the same edge are both honoured. The popped byte leaves, and the new bytes join at the tail.
- R12: After reset, the store is empty, no request is issued, and the segment and pointer hold their reset parameters (0 by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| branch_i | input | 1 | Flush the store and load a new fetch location |
| branch_cs_i | input | 16 | New code segment on branch |
| branch_ip_i | input | 16 | New fetch pointer on branch |
| data_req_i | input | 1 | Execution unit holds the bus for a data access |
| mem_req_o | output | 1 | Instruction fetch in progress on the bus |
| mem_addr_o | output | 20 | Physical fetch address |
| mem_word_o | output | 1 | 1 = word fetch, 0 = single odd byte |
| mem_rdata_i | input | 16 | Read data, valid in the last bus cycle |
| q_valid_o | output | 1 | Head byte available |
| q_byte_o | output | 8 | Head byte |
| q_ready_i | input | 1 | Execution unit takes the head byte |

## Verification
The request rises one edge after the start conditions hold. It stays high for four cycles, and the fetched bytes reach the head one edge after the fourth cycle. A flush and a pop both show on the outputs one edge after the cycle in which they were driven. The bench drives inputs on the falling edge and steps its byte-queue model once for each rising edge. At the next falling edge it compares valid, head byte, request, address and size against the model. Every latency above is therefore checked in the exact cycle it is due, and a result one cycle early or late is a mismatch.

// File: rtl/ifq_pkg.sv
package ifq_pkg;
  localparam int SEG_W  = 16;
  localparam int ADDR_W = SEG_W + 4;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;

  function automatic logic [ADDR_W-1:0] phys_addr(input logic [SEG_W-1:0] seg,
                                                  input logic [SEG_W-1:0] off);
    return {seg, 4'h0} + {4'h0, off};
  endfunction
endpackage

// File: rtl/ifq_ptr_regs.sv
module ifq_ptr_regs import ifq_pkg::*; #(
  parameter logic [SEG_W-1:0] RST_CS = '0,
  parameter logic [SEG_W-1:0] RST_IP = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [SEG_W-1:0]  cs_i,
  input  logic [SEG_W-1:0]  ip_i,
  input  logic              adv_i,
  output logic [ADDR_W-1:0] phys_o,
  output logic              word_o
);
  logic [SEG_W-1:0] cs_q, ip_q;

  assign phys_o = phys_addr(cs_q, ip_q);
  assign word_o = ~ip_q[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q <= RST_CS;
      ip_q <= RST_IP;
    end else if (load_i) begin
      cs_q <= cs_i;
      ip_q <= ip_i;
    end else if (adv_i) begin
      ip_q <= ip_q + (ip_q[0] ? SEG_W'(1) : SEG_W'(2));
    end
  end
endmodule

// File: rtl/ifq_fetch_ctrl.sv
module ifq_fetch_ctrl import ifq_pkg::*; #(
  parameter  int BUS_CYCLES = 4,
  localparam int CYC_W      = (BUS_CYCLES > 1) ? $clog2(BUS_CYCLES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              room_i,
  input  logic              data_req_i,
  input  logic              branch_i,
  input  logic [ADDR_W-1:0] fetch_addr_i,
  input  logic              fetch_word_i,
  input  logic [WORD_W-1:0] rdata_i,
  output logic              start_o,
  output logic              req_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              word_o,
  output logic              last_o,
  output logic [1:0]        push_n_o,
  output logic [WORD_W-1:0] push_data_o
);
  logic             busy_q, drop_q, word_q;
  logic [CYC_W-1:0] cyc_q;
  logic [ADDR_W-1:0] addr_q;

  assign start_o = ~busy_q & room_i & ~data_req_i & ~branch_i;
  assign last_o  = busy_q & (cyc_q == CYC_W'(BUS_CYCLES - 1));
  assign req_o   = busy_q;
  assign addr_o  = addr_q;
  assign word_o  = word_q;

  // a flush seen at any point of the bus cycle voids its data
  always_comb begin
    push_n_o = 2'd0;
    if (last_o && !drop_q && !branch_i) push_n_o = word_q ? 2'd2 : 2'd1;
  end
  assign push_data_o = word_q ? rdata_i : {{BYTE_W{1'b0}}, rdata_i[WORD_W-1:BYTE_W]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      drop_q <= 1'b0;
      word_q <= 1'b0;
      cyc_q  <= '0;
      addr_q <= '0;
    end else begin
      if (busy_q) begin
        if (last_o) begin
          busy_q <= 1'b0;
          drop_q <= 1'b0;
        end else begin
          cyc_q  <= cyc_q + CYC_W'(1);
          drop_q <= drop_q | branch_i;
        end
      end else if (start_o) begin
        busy_q <= 1'b1;
        cyc_q  <= '0;
        drop_q <= 1'b0;
        addr_q <= fetch_addr_i;
        word_q <= fetch_word_i;
      end
    end
  end
endmodule

// File: rtl/ifq_fifo.sv
module ifq_fifo import ifq_pkg::*; #(
  parameter  int DEPTH = 6,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic [1:0]        push_n_i,
  input  logic [WORD_W-1:0] push_data_i,
  input  logic              pop_i,
  output logic [BYTE_W-1:0] head_o,
  output logic [CNT_W-1:0]  count_o
);
  logic [BYTE_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  rd_q, wr_q, wr_nx1;
  logic [CNT_W-1:0]  cnt_q;
  logic [DEPTH-1:0]  we_lo, we_hi;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p, input int n);
    int s;
    s = int'(p) + n;
    if (s >= DEPTH) s = s - DEPTH;
    return PTR_W'(s);
  endfunction

  assign wr_nx1  = bump(wr_q, 1);
  assign head_o  = mem[rd_q];
  assign count_o = cnt_q;

  for (genvar i = 0; i < DEPTH; i++) begin : g_we
    assign we_lo[i] = (push_n_i != 2'd0) && (wr_q == PTR_W'(i));
    assign we_hi[i] = (push_n_i == 2'd2) && (wr_nx1 == PTR_W'(i));
  end

  always_ff @(posedge clk_i) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (we_lo[i])      mem[i] <= push_data_i[BYTE_W-1:0];
      else if (we_hi[i]) mem[i] <= push_data_i[WORD_W-1:BYTE_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (pop_i) rd_q <= bump(rd_q, 1);
      if (push_n_i != 2'd0) wr_q <= bump(wr_q, int'(push_n_i));
      cnt_q <= cnt_q + CNT_W'(push_n_i) - CNT_W'(pop_i);
    end
  end
endmodule

// File: rtl/ifetch_queue.sv
module ifetch_queue import ifq_pkg::*; #(
  parameter int               DEPTH      = 6,
  parameter int               BUS_CYCLES = 4,
  parameter logic [SEG_W-1:0] RST_CS     = '0,
  parameter logic [SEG_W-1:0] RST_IP     = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              branch_i,
  input  logic [SEG_W-1:0]  branch_cs_i,
  input  logic [SEG_W-1:0]  branch_ip_i,
  input  logic              data_req_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_word_o,
  input  logic [WORD_W-1:0] mem_rdata_i,
  output logic              q_valid_o,
  output logic [BYTE_W-1:0] q_byte_o,
  input  logic              q_ready_i
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [CNT_W-1:0]  fill_cnt;
  logic [1:0]        push_n;
  logic [WORD_W-1:0] push_data;
  logic [ADDR_W-1:0] fetch_addr;
  logic              fetch_word, start, bus_last, room, pop;

  assign room      = fill_cnt <= CNT_W'(DEPTH - 2);
  assign q_valid_o = fill_cnt != '0;
  assign pop       = q_ready_i & q_valid_o & ~branch_i;

  ifq_ptr_regs #(.RST_CS(RST_CS), .RST_IP(RST_IP)) u_ptr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (branch_i),
    .cs_i   (branch_cs_i),
    .ip_i   (branch_ip_i),
    .adv_i  (start),
    .phys_o (fetch_addr),
    .word_o (fetch_word)
  );

  ifq_fetch_ctrl #(.BUS_CYCLES(BUS_CYCLES)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .room_i       (room),
    .data_req_i   (data_req_i),
    .branch_i     (branch_i),
    .fetch_addr_i (fetch_addr),
    .fetch_word_i (fetch_word),
    .rdata_i      (mem_rdata_i),
    .start_o      (start),
    .req_o        (mem_req_o),
    .addr_o       (mem_addr_o),
    .word_o       (mem_word_o),
    .last_o       (bus_last),
    .push_n_o     (push_n),
    .push_data_o  (push_data)
  );

  ifq_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flush_i     (branch_i),
    .push_n_i    (push_n),
    .push_data_i (push_data),
    .pop_i       (pop),
    .head_o      (q_byte_o),
    .count_o     (fill_cnt)
  );
endmodule

// File: rtl/ifq_checker.sv
module ifq_checker import ifq_pkg::*; #(
  parameter  int DEPTH = 6,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              branch_i,
  input logic              data_req_i,
  input logic              mem_req_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_word_o,
  input logic              q_valid_o,
  input logic [CNT_W-1:0]  fill_cnt,
  input logic [1:0]        push_n,
  input logic              bus_last
);
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_n != 2'd0) |-> (int'(fill_cnt) + int'(push_n) <= DEPTH)); // R2
  AST_START_ROOM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_req_o) |-> (int'($past(fill_cnt)) <= DEPTH - 2)); // R2
  AST_DATA_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_req_o) |-> !$past(data_req_i)); // R7
  AST_NO_START_ON_BRANCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_req_o) |-> !$past(branch_i)); // R8
  AST_FLUSH_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(branch_i) |-> !q_valid_o); // R8
  AST_BUS_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && $past(mem_req_o) && !$past(bus_last))
      |-> ($stable(mem_addr_o) && $stable(mem_word_o))); // R6
  AST_ODD_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_addr_o[0]) |-> !mem_word_o); // R5
  AST_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_last |=> !mem_req_o); // R6
endmodule

bind ifetch_queue ifq_checker #(.DEPTH(DEPTH)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .branch_i   (branch_i),
  .data_req_i (data_req_i),
  .mem_req_o  (mem_req_o),
  .mem_addr_o (mem_addr_o),
  .mem_word_o (mem_word_o),
  .q_valid_o  (q_valid_o),
  .fill_cnt   (fill_cnt),
  .push_n     (push_n),
  .bus_last   (bus_last)
);

// File: tb/ifetch_queue_tb.sv
module ifetch_queue_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        branch_i = 1'b0;
  logic [15:0] branch_cs_i = '0, branch_ip_i = '0;
  logic        data_req_i = 1'b0;
  logic        mem_req_o, mem_word_o, q_valid_o;
  logic [19:0] mem_addr_o;
  logic [15:0] mem_rdata_i;
  logic [7:0]  q_byte_o;
  logic        q_ready_i = 1'b0;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  string tag = "R12";

  always #5 clk = ~clk;

  function automatic logic [7:0] mem_byte(input logic [19:0] a);
    return a[7:0] ^ {a[19:16], a[11:8]} ^ 8'h5A;
  endfunction

  assign mem_rdata_i = {mem_byte({mem_addr_o[19:1], 1'b1}), mem_byte({mem_addr_o[19:1], 1'b0})};

  ifetch_queue u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .branch_i(branch_i), .branch_cs_i(branch_cs_i),
    .branch_ip_i(branch_ip_i), .data_req_i(data_req_i), .mem_req_o(mem_req_o),
    .mem_addr_o(mem_addr_o), .mem_word_o(mem_word_o), .mem_rdata_i(mem_rdata_i),
    .q_valid_o(q_valid_o), .q_byte_o(q_byte_o), .q_ready_i(q_ready_i)
  );

  // reference model state (value after the latest rising edge)
  logic [7:0]  mq[$];
  bit          m_busy = 0, m_drop = 0, m_word = 0;
  int          m_cyc = 0;
  logic [19:0] m_addr = '0;
  logic [15:0] m_cs = '0, m_ip = '0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s (phase %s) actual %0h expected %0h at %0t", req, tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk(q_valid_o == (mq.size() != 0), "R10 valid", q_valid_o, mq.size() != 0);
    if (mq.size() != 0) chk(q_byte_o == mq[0], "R1 head byte", q_byte_o, mq[0]);
    chk(mem_req_o == m_busy, "R6 request", mem_req_o, m_busy);
    if (m_busy) begin
      chk(mem_addr_o == m_addr, "R3 address", mem_addr_o, m_addr);
      chk(mem_word_o == m_word, m_addr[0] ? "R5 size" : "R4 size", mem_word_o, m_word);
    end
  endtask

  task automatic model_step(input bit br, input logic [15:0] bcs, input logic [15:0] bip,
                            input bit dreq, input bit rdy);
    bit pop, last, push, go;
    pop  = rdy && mq.size() != 0 && !br;
    last = m_busy && m_cyc == 3;
    push = last && !m_drop && !br;
    go   = !m_busy && mq.size() <= 4 && !dreq && !br;
    if (pop) void'(mq.pop_front());
    if (push) begin
      if (m_word) begin
        mq.push_back(mem_byte(m_addr));
        mq.push_back(mem_byte(m_addr + 20'd1));
      end else begin
        mq.push_back(mem_byte(m_addr));
      end
    end
    if (br) begin
      mq.delete();
      m_cs = bcs;
      m_ip = bip;
    end
    if (m_busy) begin
      if (last) begin m_busy = 0; m_drop = 0; end
      else begin m_cyc++; m_drop = m_drop | br; end
    end else if (go) begin
      m_busy = 1; m_cyc = 0; m_drop = 0;
      m_addr = {m_cs, 4'h0} + {4'h0, m_ip};
      m_word = !m_ip[0];
      m_ip   = m_ip + (m_ip[0] ? 16'd1 : 16'd2);
    end
  endtask

  task automatic step(input bit br, input logic [15:0] bcs, input logic [15:0] bip,
                      input bit dreq, input bit rdy);
    @(negedge clk);
    compare();
    branch_i = br; branch_cs_i = bcs; branch_ip_i = bip;
    data_req_i = dreq; q_ready_i = rdy;
    model_step(br, bcs, bip, dreq, rdy);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R6 actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(q_valid_o == 1'b0, "R12 valid after reset", q_valid_o, 0);
    chk(mem_req_o == 1'b0, "R12 request after reset", mem_req_o, 0);
    rst_ni = 1'b1;
    model_step(0, 0, 0, 0, 0);
    @(negedge clk);
    chk(mem_req_o && mem_addr_o == 20'h00000, "R12 first fetch at reset location", mem_addr_o, 0);
    compare();
    model_step(0, 0, 0, 0, 0);

    tag = "R2";   // fill with no consumer: store tops out and requests stop
    for (int i = 0; i < 40; i++) step(0, 0, 0, 0, 0);
    chk(mem_req_o == 1'b0, "R2 no request when full", mem_req_o, 0);

    tag = "R5";   // odd target, then stream out
    step(1, 16'h1234, 16'h0011, 0, 0);
    tag = "R11";
    for (int i = 0; i < 80; i++) step(0, 0, 0, 0, 1);

    tag = "R7";   // data access holds off prefetch
    for (int i = 0; i < 30; i++) step(0, 0, 0, 1, 1);
    chk(q_valid_o == 1'b0, "R7 drained while bus held", q_valid_o, 0);
    for (int i = 0; i < 30; i++) step(0, 0, 0, (i % 7) == 3, (i % 3) != 0);

    tag = "R3";   // pointer wraps inside the segment
    step(1, 16'hF000, 16'hFFFE, 0, 0);
    for (int i = 0; i < 40; i++) step(0, 0, 0, 0, i[0]);

    tag = "R9";   // branch at every offset of a bus cycle
    for (int k = 0; k < 12; k++) begin
      for (int i = 0; i < k + 2; i++) step(0, 0, 0, 0, 1);
      step(1, 16'(16'h0100 + k * 16'h0011), 16'(k * 3 + 1), 0, k[0]);
    end
    for (int i = 0; i < 20; i++) step(0, 0, 0, 0, 1);

    tag = "R8";   // mixed random traffic
    for (int i = 0; i < 4000; i++) begin
      bit br;
      br = ($urandom % 23) == 0;
      step(br, 16'($urandom), 16'($urandom), ($urandom % 5) == 0, ($urandom % 3) != 0);
    end
    @(negedge clk);
    compare();

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule